// File: doc/BRIEF.md
# Periodic Interrupt Timer with Vectored Acknowledge

This block raises an interrupt request at a fixed interval. Software programs an 8-bit reload count and, optionally, a divide-by-512 prescaler on the incoming tick. The tick itself is a single-cycle strobe that the surrounding logic derives from the reference clock divided by four. Each time the down-counter runs out, the block latches a request. It then reloads the counter from the count field and keeps running. A control register holds the request priority level and the vector byte.

While a request is pending, the priority level appears on the level output. An arbitration query that names that level is answered with the module's arbitration ID. An acknowledge returns the vector byte and drops the request.

Writing a count of zero stops the timer. A freeze input stops it too, and a fresh count write is then needed to start it again.

Top module: `pit_vec_timer`

## Requirements
- R1: After reset, the control readback is 0x000F, the timer readback is 0x0000 and `irq_level_o` is 0.
- R2: A write to the timer register with a nonzero count field (bits 7:0), while `freeze_i` is low, starts the timer. The request becomes pending on the clock edge that takes in the count-th counted tick.
- R3: After a request, the counter reloads from the count field. The next request is pending exactly count counted ticks later, with no further write.
- R4: When timer register bit 8 is set, only every 512th input tick is counted. When it is clear, every input tick is counted.
- R5: A timer write with a count field of zero stops the timer, and no request follows however many ticks arrive.
- R6: While `freeze_i` is high, ticks are ignored and the timer stops. It stays stopped after `freeze_i` falls until a new nonzero count is written with `freeze_i` low. A count written while frozen does not start it.
- R7: `irq_level_o` equals control bits 10:8 while a request is pending, and 0 otherwise. A level of 0 hides the request but keeps it latched, so a later nonzero level shows it.
- R8: While `iack_i` is high, `vec_o` shows control bits 7:0; otherwise it shows 0. An acknowledge clears the pending request on the next edge.
- R9: `arb_id_o` equals `arb_id_i` when `arb_level_i` equals a nonzero `irq_level_o`, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timer tick strobe, one cycle wide |
| freeze_i | input | 1 | Halts and disarms the timer |
| arb_id_i | input | 4 | Arbitration ID returned on a matching query |
| ctl_we_i | input | 1 | Write strobe for the control register |
| tmr_we_i | input | 1 | Write strobe for the timer register |
| wdata_i | input | 16 | Write data for either register |
| ctl_rd_o | output | 16 | Control register readback (level 10:8, vector 7:0) |
| tmr_rd_o | output | 16 | Timer register readback (prescale 8, count 7:0) |
| iack_i | input | 1 | Interrupt acknowledge |
| vec_o | output | 8 | Vector byte during acknowledge |
| arb_level_i | input | 3 | Level named by an arbitration query |
| arb_id_o | output | 4 | Arbitration answer |
| irq_level_o | output | 3 | Pending request level, 0 when idle |

## Verification
Register readback and the request level are registered. Each one changes on the edge that samples the write, the count-th counted tick or the acknowledge. The bench therefore drives stimulus on a falling edge and checks the result at the next falling edge. `vec_o` and `arb_id_o` are combinational from the query and acknowledge inputs, so they are checked a short delay after those inputs change, before the next edge. Tick-count checks look one tick before the expected expiry, where the level must still be 0, and again at the expiry, where it must be set.

// File: rtl/pitv_pkg.sv
package pitv_pkg;
    localparam int REG_W   = 16;
    localparam int CNT_W   = 8;
    localparam int VEC_W   = 8;
    localparam int LVL_W   = 3;
    localparam int ID_W    = 4;
    localparam int LVL_LSB = 8;
    localparam int PRE_BIT = 8;
    localparam logic [VEC_W-1:0] VEC_RST = 8'h0F;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [VEC_W-1:0] vec;
    } ctl_t;

    typedef struct packed {
        logic             pre;
        logic [CNT_W-1:0] cnt;
    } tmr_t;
endpackage

// File: rtl/pitv_regs.sv
module pitv_regs
    import pitv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we_i,
    input  logic             tmr_we_i,
    input  logic [REG_W-1:0] wdata_i,
    output ctl_t             ctl_o,
    output tmr_t             tmr_o
);
    typedef struct packed {
        ctl_t ctl;
        tmr_t tmr;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ctl_we_i) begin
            r_d.ctl.lvl = wdata_i[LVL_LSB +: LVL_W];
            r_d.ctl.vec = wdata_i[VEC_W-1:0];
        end
        if (tmr_we_i) begin
            r_d.tmr.pre = wdata_i[PRE_BIT];
            r_d.tmr.cnt = wdata_i[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ctl.lvl <= '0;
            r_q.ctl.vec <= VEC_RST;
            r_q.tmr     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl_o = r_q.ctl;
    assign tmr_o = r_q.tmr;

    // R1: the control register holds its reset vector until it is written
    p_ctl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we_i |=> ctl_o == $past(ctl_o));
endmodule

// File: rtl/pitv_prescale.sv
module pitv_prescale #(
    parameter int DIV = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    input  logic sel_i,
    output logic pulse_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] pc;
    } pre_t;

    pre_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        pulse_o = 1'b0;
        if (clr_i) begin
            s_d.pc = '0;
        end else if (tick_i) begin
            if (!sel_i) begin
                pulse_o = 1'b1;
            end else if (s_q.pc == LAST) begin
                pulse_o = 1'b1;
                s_d.pc  = '0;
            end else begin
                s_d.pc = s_q.pc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: without the prescaler every tick passes straight through
    p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !sel_i && !clr_i) |-> pulse_o);
    // R4: no pulse is produced without an input tick
    p_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |-> !pulse_o);
endmodule

// File: rtl/pitv_count.sv
module pitv_count
    import pitv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_cnt_i,
    input  logic             freeze_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             run_o,
    output logic             hit_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } cnt_t;

    cnt_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        hit_o = 1'b0;
        if (load_i) begin
            s_d.cnt = load_cnt_i;
            s_d.run = (load_cnt_i != '0) && !freeze_i;
        end else if (freeze_i) begin
            s_d.run = 1'b0;
        end else if (s_q.run && step_i) begin
            if (s_q.cnt == CNT_W'(1)) begin
                hit_o   = 1'b1;
                s_d.cnt = reload_i;
                s_d.run = (reload_i != '0);
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run_o = s_q.run;

    // R6: freezing always leaves the timer stopped
    p_frozen_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |=> !run_o);
    // R5: a zero count write stops the timer
    p_zero_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_cnt_i == '0) |=> !run_o);
    // R3: an expiry with a nonzero count keeps the timer running
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && reload_i != '0) |=> run_o);
    // R2: expiry only happens while running
    p_hit_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (run_o && step_i));
endmodule

// File: rtl/pitv_req.sv
module pitv_req
    import pitv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             iack_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic [LVL_W-1:0] arb_level_i,
    input  logic [ID_W-1:0]  arb_id_i,
    output logic [LVL_W-1:0] irq_level_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [ID_W-1:0]  arb_id_o
);
    typedef struct packed {
        logic pend;
    } req_t;

    req_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hit_i)       s_d.pend = 1'b1;
        else if (iack_i) s_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_level_o = s_q.pend ? lvl_i : '0;
    assign vec_o       = iack_i ? vec_i : '0;
    assign arb_id_o    = ((irq_level_o != '0) && (arb_level_i == irq_level_o)) ? arb_id_i : '0;

    // R8: an acknowledge without a new expiry drops the request
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_i && !hit_i) |=> irq_level_o == '0);
    // R2: an expiry makes the programmed level visible next cycle
    p_hit_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> irq_level_o == lvl_i);
    // R9: nothing pending means no arbitration answer
    p_arb_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level_o == '0) |-> (arb_id_o == '0));
endmodule

// File: rtl/pit_vec_timer.sv
module pit_vec_timer
    import pitv_pkg::*;
#(
    parameter int PRE_DIV = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             freeze_i,
    input  logic [ID_W-1:0]  arb_id_i,
    input  logic             ctl_we_i,
    input  logic             tmr_we_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] ctl_rd_o,
    output logic [REG_W-1:0] tmr_rd_o,
    input  logic             iack_i,
    output logic [VEC_W-1:0] vec_o,
    input  logic [LVL_W-1:0] arb_level_i,
    output logic [ID_W-1:0]  arb_id_o,
    output logic [LVL_W-1:0] irq_level_o
);
    ctl_t ctl;
    tmr_t tmr;
    logic run, step, hit, gated_tick;

    pitv_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_we_i (ctl_we_i),
        .tmr_we_i (tmr_we_i),
        .wdata_i  (wdata_i),
        .ctl_o    (ctl),
        .tmr_o    (tmr)
    );

    assign gated_tick = tick_i && run && !freeze_i;

    pitv_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tmr_we_i),
        .tick_i  (gated_tick),
        .sel_i   (tmr.pre),
        .pulse_o (step)
    );

    pitv_count u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_we_i),
        .load_cnt_i (wdata_i[CNT_W-1:0]),
        .freeze_i   (freeze_i),
        .step_i     (step),
        .reload_i   (tmr.cnt),
        .run_o      (run),
        .hit_o      (hit)
    );

    pitv_req u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit),
        .iack_i      (iack_i),
        .lvl_i       (ctl.lvl),
        .vec_i       (ctl.vec),
        .arb_level_i (arb_level_i),
        .arb_id_i    (arb_id_i),
        .irq_level_o (irq_level_o),
        .vec_o       (vec_o),
        .arb_id_o    (arb_id_o)
    );

    always_comb begin
        ctl_rd_o = '0;
        ctl_rd_o[LVL_LSB +: LVL_W] = ctl.lvl;
        ctl_rd_o[VEC_W-1:0]        = ctl.vec;
        tmr_rd_o = '0;
        tmr_rd_o[PRE_BIT]          = tmr.pre;
        tmr_rd_o[CNT_W-1:0]        = tmr.cnt;
    end
endmodule

// File: tb/pit_vec_timer_tb_top.sv
module pit_vec_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_i, freeze_i, ctl_we_i, tmr_we_i, iack_i;
    logic [3:0]  arb_id_i, arb_id_o;
    logic [15:0] wdata_i, ctl_rd_o, tmr_rd_o;
    logic [7:0]  vec_o;
    logic [2:0]  arb_level_i, irq_level_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pit_vec_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .freeze_i(freeze_i),
        .arb_id_i(arb_id_i), .ctl_we_i(ctl_we_i), .tmr_we_i(tmr_we_i),
        .wdata_i(wdata_i), .ctl_rd_o(ctl_rd_o), .tmr_rd_o(tmr_rd_o),
        .iack_i(iack_i), .vec_o(vec_o), .arb_level_i(arb_level_i),
        .arb_id_o(arb_id_o), .irq_level_o(irq_level_o)
    );

    function automatic logic [2:0] exp_irq(bit pend, logic [2:0] lvl);
        return pend ? lvl : 3'd0;
    endfunction

    function automatic logic [3:0] exp_arb(logic [2:0] q, logic [2:0] pl, logic [3:0] id);
        return (pl != 3'd0 && q == pl) ? id : 4'd0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(logic [15:0] v);
        wdata_i = v; ctl_we_i = 1'b1;
        @(negedge clk);
        ctl_we_i = 1'b0;
    endtask

    task automatic wr_tmr(logic [15:0] v);
        wdata_i = v; tmr_we_i = 1'b1;
        @(negedge clk);
        tmr_we_i = 1'b0;
    endtask

    task automatic ticks(int n, bit gaps);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            if (gaps && ($urandom % 3) == 0) @(negedge clk);
        end
    endtask

    task automatic ack(string req, logic [7:0] vec);
        iack_i = 1'b1;
        #1 check(req, vec_o, vec);
        @(negedge clk);
        iack_i = 1'b0;
        check(req, irq_level_o, exp_irq(0, 3'd0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; tick_i = 0; freeze_i = 0; ctl_we_i = 0; tmr_we_i = 0;
        iack_i = 0; wdata_i = '0; arb_level_i = '0; arb_id_i = 4'hA;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", ctl_rd_o, 16'h000F);
        check("R1", tmr_rd_o, 16'h0000);
        check("R1", irq_level_o, 3'd0);
        ticks(4, 0);
        check("R1", irq_level_o, 3'd0);

        // R2/R3/R8/R9 random runs
        for (int it = 0; it < 6; it++) begin
            int n = 1 + ($urandom % 12);
            logic [2:0] lvl = 3'(1 + ($urandom % 7));
            logic [7:0] vec = 8'($urandom);
            arb_id_i = 4'($urandom);
            wr_ctl({5'd0, lvl, vec});
            check("R7 ctl readback", ctl_rd_o, {5'd0, lvl, vec});
            wr_tmr({8'd0, 8'(n)});
            check("R2 tmr readback", tmr_rd_o, {8'd0, 8'(n)});
            ticks(n - 1, 1);
            check("R2 before expiry", irq_level_o, exp_irq(0, lvl));
            ticks(1, 0);
            check("R2 at expiry", irq_level_o, exp_irq(1, lvl));
            arb_level_i = lvl;
            #1 check("R9 match", arb_id_o, exp_arb(lvl, lvl, arb_id_i));
            arb_level_i = lvl ^ 3'(1 + ($urandom % 7));
            #1 check("R9 mismatch", arb_id_o, exp_arb(arb_level_i, lvl, arb_id_i));
            ack("R8", vec);
            ticks(n - 1, 1);
            check("R3 before reload expiry", irq_level_o, exp_irq(0, lvl));
            ticks(1, 0);
            check("R3 reload expiry", irq_level_o, exp_irq(1, lvl));
            ack("R8", vec);
            wr_tmr(16'h0000);
        end
        iack_i = 1'b0;
        #1 check("R8 idle vector", vec_o, 8'h00);

        // R5 zero count stops
        wr_ctl(16'h0344);
        wr_tmr(16'h0003);
        ticks(1, 0);
        wr_tmr(16'h0000);
        ticks(20, 0);
        check("R5", irq_level_o, 3'd0);

        // R4 prescaler
        wr_tmr(16'h0102);
        ticks(1023, 0);
        check("R4 before expiry", irq_level_o, 3'd0);
        ticks(1, 0);
        check("R4 at expiry", irq_level_o, 3'd3);
        ack("R8", 8'h44);
        wr_tmr(16'h0000);

        // R6 freeze
        wr_tmr(16'h0003);
        freeze_i = 1'b1;
        ticks(5, 0);
        check("R6 frozen", irq_level_o, 3'd0);
        freeze_i = 1'b0;
        ticks(6, 0);
        check("R6 stays stopped", irq_level_o, 3'd0);
        freeze_i = 1'b1;
        wr_tmr(16'h0002);
        freeze_i = 1'b0;
        ticks(4, 0);
        check("R6 write while frozen", irq_level_o, 3'd0);
        wr_tmr(16'h0002);
        ticks(2, 0);
        check("R6 restart", irq_level_o, 3'd3);
        ack("R8", 8'h44);
        wr_tmr(16'h0000);

        // R7 level zero masks but latches
        wr_ctl(16'h0011);
        wr_tmr(16'h0001);
        ticks(1, 0);
        check("R7 masked", irq_level_o, 3'd0);
        arb_level_i = 3'd0;
        #1 check("R9 masked", arb_id_o, 4'd0);
        wr_tmr(16'h0000);
        wr_ctl(16'h0511);
        check("R7 unmasked", irq_level_o, 3'd5);
        ack("R8", 8'h11);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule